// File: doc/BRIEF.md
# Clock lane high-speed start and stop sequencer

This block steers the transmitter of one D-PHY style clock lane between its idle stop state and a continuous high-speed DDR clock. At rest the lane drives LP-11 on both lines, which is the condition a receiver needs before it is reset. A start request walks the lane through a fixed series of phases before the clock may oscillate. The lane drives LP-01 to request high-speed mode and then LP-00 as the bridge. Next comes a preparation phase, in which the HS driver is on but not toggling, and then a steady HS-0 clock-zero period. Only after these phases is the toggle gate opened. The lane never goes straight from LP-11 to an oscillating clock.

A stop request is accepted only while the clock is toggling. The clock keeps running for a post period, the lane then holds HS-0 for a trail period, and it returns to LP-11. Each timed phase has its own duration input. The value on that input is captured when the phase begins, and the phase lasts that value plus one cycles. The block only produces the LP line levels, the HS driver enable, a gate for an external HS clock toggle and a busy flag. The HS clock itself and the analog drivers lie outside it.

States and transitions:

- `ST_STOP` (LP-11) goes to `ST_REQ` on `start_req`.
- `ST_REQ` (LP-01) goes to `ST_BRIDGE` when its time is up.
- `ST_BRIDGE` (LP-00) goes to `ST_PREP` when its time is up.
- `ST_PREP` (HS driver on, no toggle) goes to `ST_ZERO` when its time is up.
- `ST_ZERO` (HS-0) goes to `ST_CLK` when its time is up.
- `ST_CLK` (toggling) goes to `ST_POST` on `stop_req`.
- `ST_POST` (still toggling) goes to `ST_TRAIL` when its time is up.
- `ST_TRAIL` (HS-0) goes back to `ST_STOP` when its time is up.

Top module: `clk_lane_seq`

## Requirements
- R1: While reset is asserted, and afterwards as long as no start request arrives, the lane sits in stop state: `lp_lvl`=2'b11, `hs_drv_en`=0, `clk_gate`=0, `busy`=0. `lp_lvl[1]` is the P line and `lp_lvl[0]` is the N line.
- R2: A start request sampled in stop state makes the lane drive LP-01 (`lp_lvl`=2'b01) for `t_lpx`+1 cycles. It then drives LP-00 (`lp_lvl`=2'b00, `hs_drv_en`=0) for `t_lpx`+1 cycles, always in that order.
- R3: After the bridge, `hs_drv_en`=1 with `clk_gate`=0 and `lp_lvl`=2'b00 for a preparation phase of `t_prep`+1 cycles. A clock-zero phase of `t_zero`+1 cycles follows, with the same outputs.
- R4: `clk_gate` rises only at the end of the clock-zero phase. It then stays high until a stop request arrives.
- R5: A stop request sampled while toggling keeps `clk_gate`=1 for `t_post`+1 further cycles. The lane then drives `hs_drv_en`=1 with `clk_gate`=0 for `t_trail`+1 cycles and then returns to LP-11.
- R6: A start request has no effect unless the lane is in stop state.
- R7: A stop request has no effect unless the clock is toggling, and an ignored stop request is not remembered.
- R8: `busy` is high from the first LP-01 cycle until the lane is back in LP-11, and it is low only in stop state.
- R9: The duration of each timed phase is taken from its input when the phase begins. A change to that input during the phase does not alter the phase's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Request to start the HS clock |
| stop_req | input | 1 | Request to stop the HS clock |
| t_lpx | input | CNT_W | Length code for the LP-01 and LP-00 phases |
| t_prep | input | CNT_W | Length code for the preparation phase |
| t_zero | input | CNT_W | Length code for the clock-zero phase |
| t_post | input | CNT_W | Length code for the post-stop toggling phase |
| t_trail | input | CNT_W | Length code for the trail phase |
| lp_lvl | output | 2 | LP line levels, bit 1 = P, bit 0 = N |
| hs_drv_en | output | 1 | HS driver enable |
| clk_gate | output | 1 | Gate for the HS clock toggle |
| busy | output | 1 | Lane is out of stop state |

## Verification
Every output is decoded from the registered state. A request sampled at a rising edge therefore shows up on the outputs right after that edge, and each timed phase spans exactly its length code plus one cycles. The bench drives requests and sample points at the falling edge. It holds a request across exactly one rising edge, and it walks each phase cycle by cycle against the lengths derived from the requirements. As a result, an early or late transition by even one cycle shows up in the phase being checked.

// File: rtl/clk_lane_pkg.sv
package clk_lane_pkg;

    typedef enum logic [2:0] {
        ST_STOP   = 3'd0,
        ST_REQ    = 3'd1,
        ST_BRIDGE = 3'd2,
        ST_PREP   = 3'd3,
        ST_ZERO   = 3'd4,
        ST_CLK    = 3'd5,
        ST_POST   = 3'd6,
        ST_TRAIL  = 3'd7
    } lane_st_t;

    localparam logic [1:0] LP11 = 2'b11;
    localparam logic [1:0] LP01 = 2'b01;
    localparam logic [1:0] LP00 = 2'b00;

endpackage

// File: rtl/clk_lane_timer.sv
module clk_lane_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    // Loaded on phase entry; counts down to zero, then holds.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

    // R9: once loaded, the count only moves downward until the next load
    a_r9_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q < $past(cnt_q)));

endmodule

// File: rtl/clk_lane_outdec.sv
module clk_lane_outdec
    import clk_lane_pkg::*;
(
    input  lane_st_t   state,
    output logic [1:0] lp_lvl,
    output logic       hs_drv_en,
    output logic       clk_gate,
    output logic       busy
);

    always_comb begin
        lp_lvl    = LP00;
        hs_drv_en = 1'b0;
        clk_gate  = 1'b0;
        busy      = 1'b1;
        unique case (state)
            ST_STOP: begin
                lp_lvl = LP11;
                busy   = 1'b0;
            end
            ST_REQ:    lp_lvl = LP01;
            ST_BRIDGE: lp_lvl = LP00;
            ST_PREP,
            ST_ZERO,
            ST_TRAIL:  hs_drv_en = 1'b1;
            ST_CLK,
            ST_POST: begin
                hs_drv_en = 1'b1;
                clk_gate  = 1'b1;
            end
            default: begin
                lp_lvl = LP11;
                busy   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/clk_lane_seq.sv
module clk_lane_seq
    import clk_lane_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic [CNT_W-1:0] t_lpx,
    input  logic [CNT_W-1:0] t_prep,
    input  logic [CNT_W-1:0] t_zero,
    input  logic [CNT_W-1:0] t_post,
    input  logic [CNT_W-1:0] t_trail,
    output logic [1:0]       lp_lvl,
    output logic             hs_drv_en,
    output logic             clk_gate,
    output logic             busy
);

    lane_st_t         state_q, state_d;
    logic             phase_done;
    logic             phase_load;
    logic [CNT_W-1:0] phase_len;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP:   if (start_req)  state_d = ST_REQ;
            ST_REQ:    if (phase_done) state_d = ST_BRIDGE;
            ST_BRIDGE: if (phase_done) state_d = ST_PREP;
            ST_PREP:   if (phase_done) state_d = ST_ZERO;
            ST_ZERO:   if (phase_done) state_d = ST_CLK;
            ST_CLK:    if (stop_req)   state_d = ST_POST;
            ST_POST:   if (phase_done) state_d = ST_TRAIL;
            ST_TRAIL:  if (phase_done) state_d = ST_STOP;
            default:                   state_d = ST_STOP;
        endcase
    end

    // Length code of the phase being entered
    always_comb begin
        phase_len = '0;
        unique case (state_d)
            ST_REQ,
            ST_BRIDGE: phase_len = t_lpx;
            ST_PREP:   phase_len = t_prep;
            ST_ZERO:   phase_len = t_zero;
            ST_POST:   phase_len = t_post;
            ST_TRAIL:  phase_len = t_trail;
            default:   phase_len = '0;
        endcase
    end

    assign phase_load = (state_d != state_q);

    clk_lane_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (phase_load),
        .load_val (phase_len),
        .done     (phase_done)
    );

    clk_lane_outdec u_outdec (
        .state     (state_q),
        .lp_lvl    (lp_lvl),
        .hs_drv_en (hs_drv_en),
        .clk_gate  (clk_gate),
        .busy      (busy)
    );

    // R1: from stop state the only exit is the HS request
    a_r1_stop_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP) |=> (state_q == ST_STOP || state_q == ST_REQ));

    // R2: the bridge LP-00 is entered only from LP-01
    a_r2_bridge_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_lvl == LP00 && !hs_drv_en && $past(lp_lvl) != LP00)
            |-> ($past(lp_lvl) == LP01));

    // R4: the toggle gate opens only out of the clock-zero phase
    a_r4_gate_after_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_gate) |-> ($past(state_q) == ST_ZERO));

    // R5: post toggling ends in the trail phase with the gate closed
    a_r5_post_to_trail: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POST) |=> (state_q == ST_POST ||
            (state_q == ST_TRAIL && !clk_gate && hs_drv_en)));

    // R7: a stop request outside toggling does not start the post phase
    a_r7_stop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && state_q != ST_CLK && state_q != ST_POST) |=> (state_q != ST_POST));

    // R8: busy drops only when the lane is back in LP-11 after the trail
    a_r8_busy_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (lp_lvl == LP11 && !hs_drv_en && $past(state_q) == ST_TRAIL));

endmodule

// File: tb/clk_lane_seq_bench.sv
module clk_lane_seq_bench;

    localparam int CW = 8;
    localparam int NV = 4;
    // columns: lpx, prep, zero, post, trail, toggling cycles before stop
    localparam int VEC [NV][6] = '{
        '{0, 0, 0, 0, 0, 1},
        '{1, 2, 3, 1, 2, 4},
        '{3, 0, 5, 4, 0, 2},
        '{2, 4, 1, 0, 3, 6}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_req = 1'b0;
    logic          stop_req = 1'b0;
    logic [CW-1:0] t_lpx = '0, t_prep = '0, t_zero = '0, t_post = '0, t_trail = '0;
    logic [1:0]    lp_lvl;
    logic          hs_drv_en, clk_gate, busy;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    clk_lane_seq #(.CNT_W(CW)) u_clk_lane_seq (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
        .t_lpx(t_lpx), .t_prep(t_prep), .t_zero(t_zero), .t_post(t_post),
        .t_trail(t_trail), .lp_lvl(lp_lvl), .hs_drv_en(hs_drv_en),
        .clk_gate(clk_gate), .busy(busy)
    );

    // Checks n consecutive cycles at the falling edge; one counted check per segment.
    task automatic seg(input string tag, input int n, input logic [1:0] e_lp,
                       input logic e_hs, input logic e_gate, input logic e_busy);
        bit ok = 1'b1;
        logic [4:0] got = '0;
        for (int i = 0; i < n; i++) begin
            if (ok && {lp_lvl, hs_drv_en, clk_gate, busy} !== {e_lp, e_hs, e_gate, e_busy}) begin
                ok = 1'b0;
                got = {lp_lvl, hs_drv_en, clk_gate, busy};
            end
            @(negedge clk);
        end
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got lp/hs/gate/busy=%b expected %b", tag, got,
                     {e_lp, e_hs, e_gate, e_busy});
        end
    endtask

    task automatic pulse_start();
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
    endtask

    task automatic stop_and_finish(input int post, input int trail);
        stop_req = 1'b1;
        seg("R5 stop cycle", 1, 2'b00, 1'b1, 1'b1, 1'b1);
        stop_req = 1'b0;
        seg("R5 post toggling", post + 1, 2'b00, 1'b1, 1'b1, 1'b1);
        seg("R5 trail", trail + 1, 2'b00, 1'b1, 1'b0, 1'b1);
        seg("R8 back to LP-11", 3, 2'b11, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        seg("R1 in reset", 2, 2'b11, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        seg("R1 idle after reset", 4, 2'b11, 1'b0, 1'b0, 1'b0);

        // Table-driven full start/stop cycles
        for (int v = 0; v < NV; v++) begin
            t_lpx   = CW'(VEC[v][0]);
            t_prep  = CW'(VEC[v][1]);
            t_zero  = CW'(VEC[v][2]);
            t_post  = CW'(VEC[v][3]);
            t_trail = CW'(VEC[v][4]);
            pulse_start();
            seg("R2 LP-01", VEC[v][0] + 1, 2'b01, 1'b0, 1'b0, 1'b1);
            seg("R2 LP-00", VEC[v][0] + 1, 2'b00, 1'b0, 1'b0, 1'b1);
            seg("R3 prep+zero", VEC[v][1] + VEC[v][2] + 2, 2'b00, 1'b1, 1'b0, 1'b1);
            seg("R4 toggling", VEC[v][5], 2'b00, 1'b1, 1'b1, 1'b1);
            stop_and_finish(VEC[v][3], VEC[v][4]);
        end

        // R6 and R7: start and stop pulses during the bridge are ignored
        t_lpx = 8'd2; t_prep = 8'd1; t_zero = 8'd2; t_post = 8'd1; t_trail = 8'd1;
        pulse_start();
        seg("R2 LP-01", 3, 2'b01, 1'b0, 1'b0, 1'b1);
        start_req = 1'b1; stop_req = 1'b1;
        seg("R6 R7 bridge with requests", 1, 2'b00, 1'b0, 1'b0, 1'b1);
        start_req = 1'b0; stop_req = 1'b0;
        seg("R6 R7 bridge unchanged", 2, 2'b00, 1'b0, 1'b0, 1'b1);
        stop_req = 1'b1;
        seg("R7 stop in prep ignored", 1, 2'b00, 1'b1, 1'b0, 1'b1);
        stop_req = 1'b0;
        seg("R7 prep+zero unchanged", 4, 2'b00, 1'b1, 1'b0, 1'b1);
        start_req = 1'b1;
        seg("R6 start while toggling ignored", 3, 2'b00, 1'b1, 1'b1, 1'b1);
        start_req = 1'b0;
        seg("R7 no remembered stop", 3, 2'b00, 1'b1, 1'b1, 1'b1);
        stop_and_finish(1, 1);

        // R9: change lengths after a phase has begun
        t_lpx = 8'd1; t_prep = 8'd2; t_zero = 8'd1; t_post = 8'd2; t_trail = 8'd1;
        pulse_start();
        t_lpx = 8'd6;
        seg("R9 LP-01 keeps length", 2, 2'b01, 1'b0, 1'b0, 1'b1);
        seg("R9 LP-00 takes new length", 7, 2'b00, 1'b0, 1'b0, 1'b1);
        seg("R9 prep", 3, 2'b00, 1'b1, 1'b0, 1'b1);
        t_zero = 8'd9;
        seg("R9 zero keeps length", 2, 2'b00, 1'b1, 1'b0, 1'b1);
        seg("R9 toggling starts on time", 2, 2'b00, 1'b1, 1'b1, 1'b1);
        stop_req = 1'b1;
        seg("R9 stop cycle", 1, 2'b00, 1'b1, 1'b1, 1'b1);
        stop_req = 1'b0;
        t_post = 8'd7;
        seg("R9 post keeps length", 3, 2'b00, 1'b1, 1'b1, 1'b1);
        seg("R9 trail", 2, 2'b00, 1'b1, 1'b0, 1'b1);
        seg("R1 R8 stop state again", 3, 2'b11, 1'b0, 1'b0, 1'b0);

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule